// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block adds interrupt entry to a small sequenced processor whose control is stepped by an external step counter. It holds two state bits of its own: an interrupt-enable bit and a pending bit. The enable bit is set and cleared by one-cycle commands from instruction execution. The pending bit is set only late in an instruction, after the three fetch/decode counts. This keeps the check at instruction boundaries, so a running instruction is never cut short.

While the pending bit is set, the block tells the processor to suppress its normal fetch. When the step counter next comes back to zero, the block drives a three-cycle entry instead. In the first cycle it clears the address register and copies the program counter into a temporary register. In the second it writes that temporary register to memory word 0 and clears the program counter. In the third it increments the program counter to 1, clears the step counter, and at the edge that ends the cycle drops both the pending bit and the enable bit. The service routine therefore starts at address 1 with interrupts off. A second request cannot overwrite the saved return address until software turns the enable bit on again.

The controller has four named states. `S_IDLE` means nothing is pending. `S_ARMED` means the pending bit is set and the controller waits for count 0. `S_STORE` is the memory-write step and `S_VECTOR` is the jump step. The address-clear step is the output of `S_ARMED` in the cycle the count reads 0. The transitions are:
- `S_IDLE` to `S_ARMED` on a late, enabled request.
- `S_ARMED` to `S_STORE` when the count is 0.
- `S_STORE` to `S_VECTOR` unconditionally.
- `S_VECTOR` to `S_IDLE` unconditionally.

Top module: `irq_entry_seq`

## Requirements
- R1: The interrupt request is the OR of all device flag inputs. The pending output `irq_pend` rises at the clock edge that ends a cycle in which all of the following hold: `ien` is 1, the request is high, `sc_cnt` is 3 or more, and nothing is already pending.
- R2: The pending bit never sets in a cycle where `sc_cnt` is 0, 1 or 2, and never sets while `ien` is 0, whatever the flags do.
- R3: In a cycle with `irq_pend` high and `sc_cnt` equal to 0, `ar_clr` and `tr_ld_pc` are both 1 and no other strobe is active.
- R4: In the cycle after R3's cycle, `mem_wr` and `pc_clr` are both 1 and no other strobe is active.
- R5: In the cycle after R4's cycle, `pc_inc` and `sc_clr` are both 1 and no other strobe is active. At the edge ending that cycle, `irq_pend` and `ien` both go to 0.
- R6: While `irq_pend` is high and no entry cycle is under way (count not 0), every strobe output is 0.
- R7: A cycle with `ion_cmd` high makes `ien` 1 from the next edge on. A cycle with `iof_cmd` high makes it 0. When both are high, `ien` becomes 0.
- R8: Reset, active low and asynchronous, forces `ien`, `irq_pend` and every strobe to 0.
- R9: After an entry, `ien` stays 0 and no new entry begins, even with flags held high, until `ion_cmd` is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_cnt | input | SC_W | Current value of the processor's step counter |
| dev_flag | input | NUM_FLAGS | Device ready flags; bit 0 input-ready, bit 1 output-ready |
| ion_cmd | input | 1 | One-cycle command that turns interrupts on |
| iof_cmd | input | 1 | One-cycle command that turns interrupts off |
| irq_pend | output | 1 | Pending bit; while high the normal fetch is suppressed |
| ien | output | 1 | Interrupt-enable bit |
| ar_clr | output | 1 | Clear the address register |
| tr_ld_pc | output | 1 | Load the temporary register from the program counter |
| mem_wr | output | 1 | Write the temporary register to memory at the address register |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Increment the program counter |
| sc_clr | output | 1 | Clear the step counter |

## Verification
The bench builds the block with its default values: two device flags, a four-bit step counter and three fetch counts. The four-bit counter lets the bench model instructions that run to counts 5, 6 and 7, so a request can be raised late in a long instruction and held pending across several counts before the boundary. With two flags, each source can raise a request on its own, which exposes a broken OR. Three fetch counts put the boundary between counts 2 and 3, where the block must refuse at 2 and accept at 3.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ARMED  = 2'd1,
        S_STORE  = 2'd2,
        S_VECTOR = 2'd3
    } entry_state_e;

    typedef struct packed {
        logic ar_clr;
        logic tr_ld_pc;
        logic mem_wr;
        logic pc_clr;
        logic pc_inc;
        logic sc_clr;
    } entry_strobe_t;

    localparam entry_strobe_t STROBE_NONE = '{default: 1'b0};

endpackage

// File: rtl/irq_req_or.sv
module irq_req_or #(
    parameter int NUM_FLAGS = 2
) (
    input  logic [NUM_FLAGS-1:0] flags,
    output logic                 req
);
    logic [NUM_FLAGS:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_or
            assign chain[g+1] = chain[g] | flags[g];
        end
    endgenerate

    assign req = chain[NUM_FLAGS];
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic ion,
    input  logic iof,
    input  logic entry_clr,
    output logic ien_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (iof || entry_clr) begin
            ien_q <= 1'b0;
        end else if (ion) begin
            ien_q <= 1'b1;
        end
    end

    // R7
    iof_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iof |=> !ien_q);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int SC_W        = 4,
    parameter int FETCH_STEPS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SC_W-1:0] sc_i,
    input  logic            req_i,
    input  logic            ien_i,
    output logic            pend_o,
    output logic            entry_done_o,
    output entry_strobe_t   strobe_o
);
    localparam logic [SC_W-1:0] FIRST_EXEC = SC_W'(FETCH_STEPS);

    entry_state_e state_q, state_d;
    logic         at_boundary;
    logic         late_in_instr;

    assign at_boundary   = (sc_i == '0);
    assign late_in_instr = (sc_i >= FIRST_EXEC);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (ien_i && req_i && late_in_instr) state_d = S_ARMED;
            S_ARMED:  if (at_boundary) state_d = S_STORE;
            S_STORE:  state_d = S_VECTOR;
            S_VECTOR: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        strobe_o     = STROBE_NONE;
        entry_done_o = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_ARMED: begin
                if (at_boundary) begin
                    strobe_o.ar_clr   = 1'b1;
                    strobe_o.tr_ld_pc = 1'b1;
                end
            end
            S_STORE: begin
                strobe_o.mem_wr = 1'b1;
                strobe_o.pc_clr = 1'b1;
            end
            S_VECTOR: begin
                strobe_o.pc_inc = 1'b1;
                strobe_o.sc_clr = 1'b1;
                entry_done_o    = 1'b1;
            end
            default: ;
        endcase
    end

    assign pend_o = (state_q != S_IDLE);

    // R1
    pend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(ien_i && req_i && late_in_instr));

    // R2
    no_set_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !late_in_instr) |=> !pend_o);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NUM_FLAGS   = 2,
    parameter int SC_W        = 4,
    parameter int FETCH_STEPS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SC_W-1:0]      sc_cnt,
    input  logic [NUM_FLAGS-1:0] dev_flag,
    input  logic                 ion_cmd,
    input  logic                 iof_cmd,
    output logic                 irq_pend,
    output logic                 ien,
    output logic                 ar_clr,
    output logic                 tr_ld_pc,
    output logic                 mem_wr,
    output logic                 pc_clr,
    output logic                 pc_inc,
    output logic                 sc_clr
);
    logic          req;
    logic          entry_done;
    entry_strobe_t strobes;

    irq_req_or #(.NUM_FLAGS(NUM_FLAGS)) u_req (
        .flags (dev_flag),
        .req   (req)
    );

    irq_enable_ff u_ien (
        .clk       (clk),
        .rst_n     (rst_n),
        .ion       (ion_cmd),
        .iof       (iof_cmd),
        .entry_clr (entry_done),
        .ien_q     (ien)
    );

    irq_entry_fsm #(.SC_W(SC_W), .FETCH_STEPS(FETCH_STEPS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sc_i         (sc_cnt),
        .req_i        (req),
        .ien_i        (ien),
        .pend_o       (irq_pend),
        .entry_done_o (entry_done),
        .strobe_o     (strobes)
    );

    assign ar_clr   = strobes.ar_clr;
    assign tr_ld_pc = strobes.tr_ld_pc;
    assign mem_wr   = strobes.mem_wr;
    assign pc_clr   = strobes.pc_clr;
    assign pc_inc   = strobes.pc_inc;
    assign sc_clr   = strobes.sc_clr;

    // R4
    save_then_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_clr |=> (mem_wr && pc_clr));

    // R5
    store_then_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (pc_inc && sc_clr));

    // R5
    entry_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_clr |=> (!ien && !irq_pend));

    // R3
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ar_clr, mem_wr, pc_inc}));

    // R6
    strobes_need_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_clr || mem_wr || pc_inc) |-> irq_pend);
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sc_cnt = '0;
    logic [1:0] dev_flag = '0;
    logic       ion_cmd = 1'b0;
    logic       iof_cmd = 1'b0;
    logic       irq_pend, ien, ar_clr, tr_ld_pc, mem_wr, pc_clr, pc_inc, sc_clr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    irq_entry_seq #(.NUM_FLAGS(2), .SC_W(4), .FETCH_STEPS(3)) i_irq_entry_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_cnt   (sc_cnt),
        .dev_flag (dev_flag),
        .ion_cmd  (ion_cmd),
        .iof_cmd  (iof_cmd),
        .irq_pend (irq_pend),
        .ien      (ien),
        .ar_clr   (ar_clr),
        .tr_ld_pc (tr_ld_pc),
        .mem_wr   (mem_wr),
        .pc_clr   (pc_clr),
        .pc_inc   (pc_inc),
        .sc_clr   (sc_clr)
    );

    // Expected vector bit order: pend, ien, ar_clr, tr_ld_pc, mem_wr, pc_clr, pc_inc, sc_clr
    task automatic drive(input int sc, input logic [1:0] fl, input logic on,
                         input logic off, input logic rst,
                         input logic [7:0] exp, input string tag);
        @(negedge clk);
        sc_cnt   = 4'(sc);
        dev_flag = fl;
        ion_cmd  = on;
        iof_cmd  = off;
        rst_n    = !rst;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                logic [7:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {irq_pend, ien, ar_clr, tr_ld_pc, mem_wr, pc_clr, pc_inc, sc_clr};
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %b expected %b", t, a, e);
                end
            end
        end
    end

    initial begin : watchdog
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        drive(0, 2'b00, 0, 0, 1, 8'h00, "R8 reset");
        drive(0, 2'b00, 0, 0, 1, 8'h00, "R8 reset");
        // flags high while disabled
        drive(3, 2'b11, 0, 0, 0, 8'h00, "R2 disabled");
        drive(4, 2'b11, 0, 0, 0, 8'h00, "R2 disabled");
        drive(0, 2'b00, 1, 0, 0, 8'h00, "R7 ion issued");
        // enabled, flag during fetch counts
        drive(1, 2'b01, 0, 0, 0, 8'h40, "R7 ion took");
        drive(2, 2'b01, 0, 0, 0, 8'h40, "R2 fetch count 2");
        drive(0, 2'b01, 0, 0, 0, 8'h40, "R2 fetch count 0");
        drive(3, 2'b01, 0, 0, 0, 8'h40, "R1 late request");
        drive(4, 2'b00, 0, 0, 0, 8'hC0, "R6 pending quiet");
        drive(0, 2'b00, 0, 0, 0, 8'hF0, "R3 save step");
        drive(1, 2'b00, 0, 0, 0, 8'hCC, "R4 store step");
        drive(2, 2'b00, 0, 0, 0, 8'hC3, "R5 vector step");
        drive(0, 2'b11, 0, 0, 0, 8'h00, "R5 after entry");
        drive(3, 2'b11, 0, 0, 0, 8'h00, "R9 no reentry");
        drive(4, 2'b11, 0, 0, 0, 8'h00, "R9 no reentry");
        // command priority
        drive(0, 2'b00, 1, 1, 0, 8'h00, "R7 both commands");
        drive(1, 2'b00, 0, 0, 0, 8'h00, "R7 off wins");
        drive(3, 2'b00, 1, 0, 0, 8'h00, "R7 ion issued");
        drive(4, 2'b00, 0, 1, 0, 8'h40, "R7 ion took");
        drive(1, 2'b00, 0, 0, 0, 8'h00, "R7 iof took");
        // second flag alone, long instruction
        drive(0, 2'b00, 1, 0, 0, 8'h00, "R7 ion issued");
        drive(5, 2'b10, 0, 0, 0, 8'h40, "R1 output flag");
        drive(6, 2'b00, 0, 0, 0, 8'hC0, "R6 pending quiet");
        drive(7, 2'b00, 0, 0, 0, 8'hC0, "R6 pending quiet");
        drive(0, 2'b00, 0, 0, 0, 8'hF0, "R3 save step");
        drive(1, 2'b00, 0, 0, 0, 8'hCC, "R4 store step");
        drive(2, 2'b00, 0, 0, 0, 8'hC3, "R5 vector step");
        drive(0, 2'b10, 0, 0, 0, 8'h00, "R5 after entry");
        drive(5, 2'b10, 0, 0, 0, 8'h00, "R9 no reentry");
        // reset while pending
        drive(0, 2'b00, 1, 0, 0, 8'h00, "R7 ion issued");
        drive(3, 2'b01, 0, 0, 0, 8'h40, "R1 late request");
        drive(0, 2'b01, 0, 0, 1, 8'h00, "R8 reset while pending");
        drive(3, 2'b01, 0, 0, 0, 8'h00, "R8 enable cleared");
        drive(4, 2'b01, 0, 0, 0, 8'h00, "R8 stays idle");
        @(negedge clk);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule